// File: doc/BRIEF.md
# Audio Clock Divider Chain

This block derives the clocks an audio serial port needs from a fast fabric clock. It picks one of two source tick streams (a peripheral tick or an audio bus tick), optionally slows it with an integer prescaler to form the root tick, and then divides the root tick down to a bit clock and a left/right frame clock. Each half-period of the bit clock and each frame length is counted in root ticks. Single-cycle strobes on bit-clock edges and at frame start let a serializer in the same fabric clock domain shift data without sampling the generated clocks. Source clocks are supplied as clock-enable pulses in the fabric domain. Any change of source or prescaler must be made with the block disabled.

The frame length and the bits-per-frame ratio each come from a small fixed set, including non-power-of-two members. A ratio change requested while running waits for the current frame to finish. A pair whose bit-clock half-period would not be a whole number of root ticks is flagged and never adopted. In slave mode the bit clock and frame clock come from pins, pass through synchronizers, and drive the same outputs and strobes. The codec master clock pin can be an output, toggling on every root tick, or an input whose rising edges replace the root tick.

Top module: `audio_clk_chain`

## Requirements
- R1: With `src_sel_i`=0 root ticks come only from `periph_tick_i`; with `src_sel_i`=1 only from `abus_tick_i`. The unselected tick input has no effect on any output.
- R2: With `psc_en_i`=1 and `psc_div_i`=N, one root tick is made per N+1 selected source ticks. With `psc_en_i`=0 every source tick is a root tick, whatever `psc_div_i` holds.
- R3: `rclk_ratio_i` values 0, 1, 2, 3 give frames of 256, 384, 512, 768 root ticks. `lr_o` is low for the first half of a frame and high for the second half.
- R4: `bclk_ratio_i` values 0, 1, 2, 3 give 16, 24, 32, 48 bit-clock periods per frame. Each level of `bclk_o` lasts frame/(2*bits) root ticks, and `bclk_o` starts each frame low.
- R5: `bclk_rise_stb_o` and `bclk_fall_stb_o` pulse for one cycle, in the first cycle `bclk_o` shows its new level. `frame_stb_o` pulses in the cycle `lr_o` returns low at a frame start. `lr_o` only changes together with a falling bit-clock edge.
- R6: While `en_i`=0, `bclk_o`, `lr_o`, `mclk_o` and all strobes stay low. After `en_i` rises, a frame starts at its first position with `bclk_o` low. With the source ticking every cycle and no prescaler, the first rise of `bclk_o` is seen H+1 cycles after `en_i` is sampled high, where H is the half-period in root ticks.
- R7: A ratio change made while running takes effect only at the next frame start. The frame in progress keeps its old length.
- R8: A requested pair with a 256 or 512 frame and 24 or 48 bits per frame is invalid. `cfg_err_o` is high in the cycle after such a pair is presented, and the block keeps the last valid pair.
- R9: With `slave_i`=1, `bclk_o` and `lr_o` follow `ext_bclk_i` and `ext_lr_i` two cycles late. The strobes come from edges of the synchronized pins, with `frame_stb_o` on a falling `ext_lr_i`. The internal divider does not affect the outputs.
- R10: With `mclk_in_i`=0, `mclk_oe_o`=1 and `mclk_o` toggles on every root tick. With `mclk_in_i`=1, `mclk_oe_o`=0, `mclk_o` is low, and each synchronized rising edge of `ext_mclk_i` is one root tick (the prescaler and source ticks are unused).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Run enable |
| src_sel_i | input | 1 | Source select: 0 peripheral tick, 1 audio bus tick |
| periph_tick_i | input | 1 | Peripheral source tick |
| abus_tick_i | input | 1 | Audio bus source tick |
| psc_en_i | input | 1 | Prescaler enable |
| psc_div_i | input | PSC_W | Prescaler value N (divide by N+1) |
| rclk_ratio_i | input | 2 | Frame length select |
| bclk_ratio_i | input | 2 | Bits-per-frame select |
| slave_i | input | 1 | Take bit and frame clocks from pins |
| mclk_in_i | input | 1 | Codec master clock pin is an input |
| ext_mclk_i | input | 1 | External codec master clock |
| ext_bclk_i | input | 1 | External bit clock (slave) |
| ext_lr_i | input | 1 | External frame clock (slave) |
| mclk_o | output | 1 | Codec master clock out |
| mclk_oe_o | output | 1 | Codec master clock pin drive enable |
| bclk_o | output | 1 | Bit clock |
| lr_o | output | 1 | Left/right frame clock |
| bclk_rise_stb_o | output | 1 | Bit clock rising strobe |
| bclk_fall_stb_o | output | 1 | Bit clock falling strobe |
| frame_stb_o | output | 1 | Frame start strobe |
| cfg_err_o | output | 1 | Requested ratio pair is invalid |

## Verification
A corrupted position or half-period counter shows at the pins as a wrong `bclk_o` or `lr_o` period or a misplaced `frame_stb_o`, within one frame (at most 768 root ticks). The bench therefore measures periods, high times and frame spacings directly. A ratio latched at the wrong moment shows as a shortened or stretched frame around the change. A wrong prescaler count scales every measured period by the wrong factor. Synchronizer or edge-detect faults in slave and codec-input modes show as missing or extra strobes a few cycles after a pin edge.

// File: rtl/acd_pkg.sv
package acd_pkg;

    localparam int POS_W = 10;   // holds positions up to 767
    localparam int HB_W  = 5;    // holds bit-clock half periods up to 24

    typedef logic [1:0] ratio_sel_t;

    // Root ticks per frame for a frame-length select
    function automatic logic [POS_W-1:0] frame_len(input ratio_sel_t s);
        case (s)
            2'd0:    return POS_W'(256);
            2'd1:    return POS_W'(384);
            2'd2:    return POS_W'(512);
            default: return POS_W'(768);
        endcase
    endfunction

    // 256 and 512 cannot carry 24 or 48 bits with whole half periods
    function automatic logic cfg_ok(input ratio_sel_t rs, input ratio_sel_t bs);
        return !(!rs[0] && bs[0]);
    endfunction

    // Root ticks per bit-clock level: frame / (2 * bits)
    function automatic logic [HB_W-1:0] half_bclk(input ratio_sel_t rs, input ratio_sel_t bs);
        case ({rs, bs})
            4'b00_00: return HB_W'(8);
            4'b00_10: return HB_W'(4);
            4'b01_00: return HB_W'(12);
            4'b01_01: return HB_W'(8);
            4'b01_10: return HB_W'(6);
            4'b01_11: return HB_W'(4);
            4'b10_00: return HB_W'(16);
            4'b10_10: return HB_W'(8);
            4'b11_00: return HB_W'(24);
            4'b11_01: return HB_W'(16);
            4'b11_10: return HB_W'(12);
            4'b11_11: return HB_W'(8);
            default:  return HB_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/acd_root_gen.sv
module acd_root_gen #(
    parameter int PSC_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             src_sel_i,
    input  logic             periph_tick_i,
    input  logic             abus_tick_i,
    input  logic             psc_en_i,
    input  logic [PSC_W-1:0] psc_val_i,
    input  logic             mclk_in_mode_i,
    input  logic             ext_mclk_i,
    output logic             root_tick_o,
    output logic             mclk_o
);

    localparam int SH_W = SYNC_STAGES + 1;

    typedef struct packed {
        logic [PSC_W-1:0] cnt;
        logic             tick;
        logic             mclk;
        logic [SH_W-1:0]  sh;
    } st_t;

    st_t  q, d;
    logic src_tick;
    logic ext_rise;
    logic fire;

    always_comb begin
        d        = q;
        fire     = 1'b0;
        d.sh     = {q.sh[SH_W-2:0], ext_mclk_i};
        src_tick = src_sel_i ? abus_tick_i : periph_tick_i;
        ext_rise = q.sh[SH_W-2] & ~q.sh[SH_W-1];
        if (!en_i) begin
            d.cnt  = '0;
            d.tick = 1'b0;
            d.mclk = 1'b0;
        end else if (mclk_in_mode_i) begin
            d.cnt  = '0;
            d.tick = ext_rise;
            d.mclk = 1'b0;
        end else begin
            if (src_tick) begin
                if (!psc_en_i || (q.cnt >= psc_val_i)) begin
                    fire  = 1'b1;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + PSC_W'(1);
                end
            end
            d.tick = fire;
            if (fire) begin
                d.mclk = ~q.mclk;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign root_tick_o = q.tick;
    assign mclk_o      = q.mclk;

    AST_PSC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (q.tick && en_i && psc_en_i && !mclk_in_mode_i && psc_val_i != '0)
        |=> (!q.tick || psc_val_i == '0 || !psc_en_i || mclk_in_mode_i)); // R2

    AST_MCLK_QUIET_IN: assert property (@(posedge clk) disable iff (!rst_n)
        mclk_in_mode_i |=> !q.mclk); // R10

endmodule

// File: rtl/acd_frame_div.sv
module acd_frame_div
    import acd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       tick_i,
    input  ratio_sel_t rsel_i,
    input  ratio_sel_t bsel_i,
    output logic       bclk_o,
    output logic       lr_o,
    output logic       rise_o,
    output logic       fall_o,
    output logic       frame_o,
    output logic       cfg_err_o
);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic [HB_W-1:0]  bcnt;
        logic             bclk;
        logic             lr;
        logic             rise;
        logic             fall;
        logic             frame;
        ratio_sel_t       act_r;
        ratio_sel_t       act_b;
        logic             err;
    } st_t;

    st_t              q, d;
    logic             req_ok;
    logic [POS_W-1:0] flen;
    logic [POS_W-1:0] pos_inc;
    logic [HB_W-1:0]  hb;

    always_comb begin
        d       = q;
        d.rise  = 1'b0;
        d.fall  = 1'b0;
        d.frame = 1'b0;
        req_ok  = cfg_ok(rsel_i, bsel_i);
        d.err   = !req_ok;
        flen    = frame_len(q.act_r);
        hb      = half_bclk(q.act_r, q.act_b);
        pos_inc = q.pos + POS_W'(1);
        if (!en_i) begin
            d.pos  = '0;
            d.bcnt = '0;
            d.bclk = 1'b0;
            d.lr   = 1'b0;
            if (req_ok) begin
                d.act_r = rsel_i;
                d.act_b = bsel_i;
            end
        end else if (tick_i) begin
            if (q.pos == flen - POS_W'(1)) begin
                d.pos   = '0;
                d.bcnt  = '0;
                d.bclk  = 1'b0;
                d.lr    = 1'b0;
                d.frame = 1'b1;
                d.fall  = q.bclk;
                if (req_ok) begin
                    d.act_r = rsel_i;
                    d.act_b = bsel_i;
                end
            end else begin
                d.pos = pos_inc;
                if (q.bcnt == hb - HB_W'(1)) begin
                    d.bcnt = '0;
                    d.bclk = ~q.bclk;
                    d.rise = ~q.bclk;
                    d.fall = q.bclk;
                end else begin
                    d.bcnt = q.bcnt + HB_W'(1);
                end
                d.lr = (pos_inc >= (flen >> 1));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign bclk_o    = q.bclk;
    assign lr_o      = q.lr;
    assign rise_o    = q.rise;
    assign fall_o    = q.fall;
    assign frame_o   = q.frame;
    assign cfg_err_o = q.err;

    AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.rise && q.fall)); // R5

    AST_LR_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en_i) && !$stable(q.lr)) |-> $fell(q.bclk)); // R5

    AST_FRAME_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        q.frame |-> (!q.lr && !q.bclk && q.pos == '0)); // R3

    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (q.pos == '0 && !q.bclk && !q.lr)); // R6

    AST_RATIO_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(q.act_r) || !$stable(q.act_b)) |-> (q.frame || !$past(en_i))); // R7

    AST_ACTIVE_PAIR_OK: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ok(q.act_r, q.act_b)); // R8

endmodule

// File: rtl/acd_edge_sync.sv
module acd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic toggle_o
);

    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], pin_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign level_o  = sh_q[STAGES-1];
    assign toggle_o = sh_q[STAGES-1] ^ sh_q[STAGES];

endmodule

// File: rtl/audio_clk_chain.sv
module audio_clk_chain
    import acd_pkg::*;
#(
    parameter int PSC_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             src_sel_i,
    input  logic             periph_tick_i,
    input  logic             abus_tick_i,
    input  logic             psc_en_i,
    input  logic [PSC_W-1:0] psc_div_i,
    input  logic [1:0]       rclk_ratio_i,
    input  logic [1:0]       bclk_ratio_i,
    input  logic             slave_i,
    input  logic             mclk_in_i,
    input  logic             ext_mclk_i,
    input  logic             ext_bclk_i,
    input  logic             ext_lr_i,
    output logic             mclk_o,
    output logic             mclk_oe_o,
    output logic             bclk_o,
    output logic             lr_o,
    output logic             bclk_rise_stb_o,
    output logic             bclk_fall_stb_o,
    output logic             frame_stb_o,
    output logic             cfg_err_o
);

    localparam int N_EXT  = 2;  // channel 0 bit clock, channel 1 frame clock
    localparam int CH_BCK = 0;
    localparam int CH_LR  = 1;

    logic             master_en;
    logic             root_tick;
    logic             m_bclk, m_lr, m_rise, m_fall, m_frame, m_err;
    logic [N_EXT-1:0] ext_pins;
    logic [N_EXT-1:0] ext_lvl;
    logic [N_EXT-1:0] ext_tgl;

    assign master_en = en_i & ~slave_i;
    assign ext_pins  = {ext_lr_i, ext_bclk_i};

    acd_root_gen #(
        .PSC_W       (PSC_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_root (
        .clk            (clk),
        .rst_n          (rst_n),
        .en_i           (en_i),
        .src_sel_i      (src_sel_i),
        .periph_tick_i  (periph_tick_i),
        .abus_tick_i    (abus_tick_i),
        .psc_en_i       (psc_en_i),
        .psc_val_i      (psc_div_i),
        .mclk_in_mode_i (mclk_in_i),
        .ext_mclk_i     (ext_mclk_i),
        .root_tick_o    (root_tick),
        .mclk_o         (mclk_o)
    );

    acd_frame_div u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (master_en),
        .tick_i    (root_tick),
        .rsel_i    (rclk_ratio_i),
        .bsel_i    (bclk_ratio_i),
        .bclk_o    (m_bclk),
        .lr_o      (m_lr),
        .rise_o    (m_rise),
        .fall_o    (m_fall),
        .frame_o   (m_frame),
        .cfg_err_o (m_err)
    );

    for (genvar ch = 0; ch < N_EXT; ch++) begin : g_ext
        acd_edge_sync #(
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_i    (ext_pins[ch]),
            .level_o  (ext_lvl[ch]),
            .toggle_o (ext_tgl[ch])
        );
    end

    always_comb begin
        if (slave_i) begin
            bclk_o          = en_i & ext_lvl[CH_BCK];
            lr_o            = en_i & ext_lvl[CH_LR];
            bclk_rise_stb_o = en_i & ext_tgl[CH_BCK] & ext_lvl[CH_BCK];
            bclk_fall_stb_o = en_i & ext_tgl[CH_BCK] & ~ext_lvl[CH_BCK];
            frame_stb_o     = en_i & ext_tgl[CH_LR] & ~ext_lvl[CH_LR];
        end else begin
            bclk_o          = m_bclk;
            lr_o            = m_lr;
            bclk_rise_stb_o = m_rise;
            bclk_fall_stb_o = m_fall;
            frame_stb_o     = m_frame;
        end
    end

    assign mclk_oe_o = ~mclk_in_i;
    assign cfg_err_o = m_err;

    AST_OUT_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bclk_rise_stb_o && bclk_fall_stb_o)); // R5

endmodule

// File: tb/test_audio_clk_chain.sv
module test_audio_clk_chain;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b0;
    logic       src_sel_i = 1'b0;
    logic       periph_tick_i = 1'b1;
    logic       abus_tick_i = 1'b0;
    logic       psc_en_i = 1'b0;
    logic [7:0] psc_div_i = 8'd0;
    logic [1:0] rclk_ratio_i = 2'd0;
    logic [1:0] bclk_ratio_i = 2'd0;
    logic       slave_i = 1'b0;
    logic       mclk_in_i = 1'b0;
    logic       ext_mclk_i = 1'b0;
    logic       ext_bclk_i = 1'b0;
    logic       ext_lr_i = 1'b0;
    logic       mclk_o, mclk_oe_o, bclk_o, lr_o;
    logic       bclk_rise_stb_o, bclk_fall_stb_o, frame_stb_o, cfg_err_o;

    int checks = 0;
    int fails  = 0;
    int rise_cnt = 0;
    int frame_cnt = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    audio_clk_chain i_audio_clk_chain (
        .clk             (clk),
        .rst_n           (rst_n),
        .en_i            (en_i),
        .src_sel_i       (src_sel_i),
        .periph_tick_i   (periph_tick_i),
        .abus_tick_i     (abus_tick_i),
        .psc_en_i        (psc_en_i),
        .psc_div_i       (psc_div_i),
        .rclk_ratio_i    (rclk_ratio_i),
        .bclk_ratio_i    (bclk_ratio_i),
        .slave_i         (slave_i),
        .mclk_in_i       (mclk_in_i),
        .ext_mclk_i      (ext_mclk_i),
        .ext_bclk_i      (ext_bclk_i),
        .ext_lr_i        (ext_lr_i),
        .mclk_o          (mclk_o),
        .mclk_oe_o       (mclk_oe_o),
        .bclk_o          (bclk_o),
        .lr_o            (lr_o),
        .bclk_rise_stb_o (bclk_rise_stb_o),
        .bclk_fall_stb_o (bclk_fall_stb_o),
        .frame_stb_o     (frame_stb_o),
        .cfg_err_o       (cfg_err_o)
    );

    always @(posedge clk) begin
        if (bclk_rise_stb_o) rise_cnt <= rise_cnt + 1;
        if (frame_stb_o)     frame_cnt <= frame_cnt + 1;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // 0 frame strobe spacing, 1 rise strobe spacing, 2 lr period,
    // 3 mclk period, 4 lr high time
    task automatic meas(input int sel, output int cyc);
        int   n = 0;
        bit   got = 1'b0;
        bit   hit;
        logic p_lr = lr_o;
        logic p_m  = mclk_o;
        cyc = -1;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            case (sel)
                0:       hit = frame_stb_o;
                1:       hit = bclk_rise_stb_o;
                2:       hit = lr_o && !p_lr;
                3:       hit = mclk_o && !p_m;
                default: hit = got ? !lr_o : (lr_o && !p_lr);
            endcase
            p_lr = lr_o;
            p_m  = mclk_o;
            if (got) n++;
            if (hit) begin
                if (got) begin
                    cyc = n;
                    break;
                end
                got = 1'b1;
                n   = 0;
            end
        end
    endtask

    task automatic restart();
        @(negedge clk);
        en_i = 1'b0;
        @(negedge clk);
        en_i = 1'b1;
    endtask

    task automatic t_reset();
        chk("R6", "bclk after reset", bclk_o, 0);
        chk("R6", "lr after reset", lr_o, 0);
        chk("R6", "frame strobe after reset", frame_stb_o, 0);
        chk("R6", "mclk idle", mclk_o, 0);
        chk("R10", "mclk drive enabled", mclk_oe_o, 1);
        chk("R8", "no config error for 256/16", cfg_err_o, 0);
    endtask

    task automatic t_start();
        int c;
        rclk_ratio_i = 2'd0;
        bclk_ratio_i = 2'd0;
        restart();
        repeat (8) @(negedge clk);
        chk("R6", "bclk still low before first half period", bclk_o, 0);
        @(negedge clk);
        chk("R6", "bclk high after first half period", bclk_o, 1);
        chk("R5", "rise strobe with first rise", bclk_rise_stb_o, 1);
        meas(3, c);
        chk("R10", "mclk period at one root tick per cycle", c, 2);
    endtask

    task automatic t_ratios();
        int c;
        int rs [6] = '{0, 1, 2, 3, 1, 3};
        int bs [6] = '{0, 1, 2, 3, 3, 0};
        int fl [4] = '{256, 384, 512, 768};
        int bp [4] = '{16, 24, 32, 48};
        for (int k = 0; k < 6; k++) begin
            rclk_ratio_i = 2'(rs[k]);
            bclk_ratio_i = 2'(bs[k]);
            restart();
            meas(0, c);
            chk("R3", "frame length", c, fl[rs[k]]);
            meas(2, c);
            chk("R3", "lr period", c, fl[rs[k]]);
            meas(4, c);
            chk("R3", "lr high time", c, fl[rs[k]] / 2);
            meas(1, c);
            chk("R4", "bclk period", c, fl[rs[k]] / bp[bs[k]]);
        end
    endtask

    task automatic t_prescaler();
        int c;
        rclk_ratio_i = 2'd0;
        bclk_ratio_i = 2'd0;
        psc_en_i  = 1'b1;
        psc_div_i = 8'd2;
        restart();
        meas(0, c);
        chk("R2", "frame with divide by 3", c, 768);
        meas(1, c);
        chk("R2", "bclk with divide by 3", c, 48);
        @(negedge clk);
        en_i      = 1'b0;
        psc_en_i  = 1'b0;
        psc_div_i = 8'd5;
        restart();
        meas(0, c);
        chk("R2", "prescaler off ignores value", c, 256);
    endtask

    task automatic t_source();
        int c;
        int r0;
        @(negedge clk);
        en_i          = 1'b0;
        periph_tick_i = 1'b0;
        abus_tick_i   = 1'b1;
        src_sel_i     = 1'b0;
        restart();
        r0 = rise_cnt;
        repeat (300) @(negedge clk);
        chk("R1", "unselected bus tick gives no bclk rises", rise_cnt - r0, 0);
        chk("R1", "bclk stays low", bclk_o, 0);
        @(negedge clk);
        en_i      = 1'b0;
        src_sel_i = 1'b1;
        restart();
        meas(0, c);
        chk("R1", "frame from bus tick", c, 256);
        @(negedge clk);
        en_i          = 1'b0;
        src_sel_i     = 1'b0;
        periph_tick_i = 1'b1;
        abus_tick_i   = 1'b0;
    endtask

    task automatic t_cfg_err();
        int c;
        rclk_ratio_i = 2'd2;
        bclk_ratio_i = 2'd2;
        restart();
        @(negedge clk);
        bclk_ratio_i = 2'd1;
        @(negedge clk);
        chk("R8", "error flag for 512/24", cfg_err_o, 1);
        meas(0, c);
        meas(0, c);
        chk("R8", "frame keeps last valid length", c, 512);
        meas(1, c);
        chk("R8", "bclk keeps last valid ratio", c, 16);
        bclk_ratio_i = 2'd2;
        @(negedge clk);
        @(negedge clk);
        chk("R8", "error flag clears for 512/32", cfg_err_o, 0);
    endtask

    task automatic t_midframe();
        int n = 0;
        int c;
        rclk_ratio_i = 2'd0;
        bclk_ratio_i = 2'd0;
        restart();
        meas(0, c);
        while (!frame_stb_o) @(negedge clk);
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            n++;
            if (n == 50) rclk_ratio_i = 2'd2;
            if (frame_stb_o) break;
        end
        chk("R7", "frame in progress keeps old length", n, 256);
        meas(0, c);
        chk("R7", "next frames use new length", c, 512);
    endtask

    task automatic t_slave();
        int r0;
        int f0;
        @(negedge clk);
        slave_i    = 1'b1;
        ext_bclk_i = 1'b0;
        ext_lr_i   = 1'b0;
        en_i       = 1'b1;
        repeat (5) @(negedge clk);
        r0 = rise_cnt;
        f0 = frame_cnt;
        ext_bclk_i = 1'b1;
        @(negedge clk);
        chk("R9", "bclk not yet through synchronizer", bclk_o, 0);
        repeat (2) @(negedge clk);
        chk("R9", "bclk follows pin", bclk_o, 1);
        chk("R9", "one rise strobe from pin edge", rise_cnt - r0, 1);
        repeat (300) @(negedge clk);
        chk("R9", "internal divider not visible on bclk", bclk_o, 1);
        chk("R9", "internal divider not visible on lr", lr_o, 0);
        chk("R9", "no extra rises while pin static", rise_cnt - r0, 1);
        ext_lr_i = 1'b1;
        repeat (4) @(negedge clk);
        chk("R9", "lr follows pin", lr_o, 1);
        ext_lr_i = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9", "frame strobe on falling lr pin", frame_cnt - f0, 1);
        en_i       = 1'b0;
        slave_i    = 1'b0;
        ext_bclk_i = 1'b0;
    endtask

    task automatic t_mclk_in();
        int c;
        rclk_ratio_i = 2'd0;
        bclk_ratio_i = 2'd0;
        @(negedge clk);
        mclk_in_i = 1'b1;
        fork
            begin
                for (int i = 0; i < 8000; i++) begin
                    @(negedge clk);
                    if (i % 2 == 1) ext_mclk_i = ~ext_mclk_i;
                end
            end
        join_none
        restart();
        @(negedge clk);
        chk("R10", "mclk drive off in input mode", mclk_oe_o, 0);
        meas(0, c);
        chk("R10", "frame timed by pin rising edges", c, 1024);
        chk("R10", "mclk output low in input mode", mclk_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_start();
        t_ratios();
        t_prescaler();
        t_source();
        t_cfg_err();
        t_midframe();
        t_slave();
        t_mclk_in();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule